// File: doc/BRIEF.md
# PHY Power-Up Sequencer with Poll Timeouts

This block takes an interface PHY's analog front end in or out of power-down. A start request runs the full bring-up. Both the power-down-bar and DLL enable outputs are first driven low, and the block waits a settle interval. It then raises power-down-bar and waits for the pad calibration to report completion. Next it programs a DLL frequency band and enables the DLL. Last, it waits for DLL lock. A stop request only drives the two controls low and then finishes.

Each wait for an analog status input has its own timeout. The calibration timeout is short and the DLL lock timeout is long. If either one expires, the sequence ends with an error pulse. A measured card-clock rate, given in kHz, selects the frequency band. The same rate input raises a warning when it lies too far from the ideal rate of its band. A rate of zero means no clock is running. In that case the DLL is enabled but its lock is not awaited. All delays are counted in cycles of the block clock, which are derived from a clock-frequency parameter.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, pdb_o, dll_en_o, fsel_o, busy_o, done_o, err_o and warn_o are all 0.
- R2: When a request is accepted, pdb_o and dll_en_o are both 0 in the next cycle. For a stop, done_o pulses in the cycle after that.
- R3: For a start, pdb_o rises exactly 1 + SETTLE_US×(CLK_HZ/10^6) cycles after the acceptance cycle.
- R4: If cal_done_i stays low for CAL_TMO_US×(CLK_HZ/10^6) cycles after pdb_o rises, err_o pulses and dll_en_o stays 0.
- R5: Once calibration is done, fsel_o takes the band code, and dll_en_o rises one cycle later. While dll_en_o is high, fsel_o does not change.
- R6: If the latched rate is 0, done_o pulses in the cycle in which dll_en_o first reads 1.
- R7: If the rate is not 0, the block waits for dll_rdy_i. When dll_rdy_i is seen, done_o pulses. If DLL_TMO_US×(CLK_HZ/10^6) cycles pass without it, err_o pulses and dll_en_o stays 1.
- R8: The rate is latched when a start is accepted. The band codes on fsel_o are: 0 for a rate of 0 or for 175000 kHz and above; 1 for 1 to 74999 kHz; 2 for 75000 to 124999 kHz; 3 for 125000 to 174999 kHz.
- R9: warn_o is updated when a start is accepted. It is 1 when the rate exceeds 200000 kHz, or when the rate exceeds 50000 kHz and differs from its band's ideal rate by more than 15000 kHz. The ideal rates are 50000, 100000, 150000 and 200000 kHz for codes 1, 2, 3 and 0. warn_o is cleared when a stop is accepted.
- R10: busy_o is high from the cycle after acceptance until the cycle of done_o or err_o. While busy_o is high, start_i and stop_i are ignored. If both are asserted while idle, start wins.
- R11: done_o and err_o are single-cycle pulses, and they never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Power-on request |
| stop_i | input | 1 | Power-off request |
| rate_khz_i | input | RATE_W | Measured card-clock rate in kHz |
| cal_done_i | input | 1 | Pad calibration complete |
| dll_rdy_i | input | 1 | DLL locked |
| pdb_o | output | 1 | Power-down-bar to the PHY |
| dll_en_o | output | 1 | DLL enable |
| fsel_o | output | 2 | DLL frequency band code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Poll timeout pulse |
| warn_o | output | 1 | Rate out of supported range |

## Verification
The bench builds the block with CLK_HZ at 4 MHz and DLL_TMO_US at 100. At these values the settle wait is 12 cycles, the calibration timeout is 200 cycles and the lock timeout is 400 cycles. Both timeouts then expire in a few hundred cycles, and the count of each cycle up to the expiry edge is compared. The rates used straddle every band edge and both warning thresholds, and they include zero.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned SETTLE_US  = 3,
  parameter int unsigned CAL_TMO_US = 50,
  parameter int unsigned DLL_TMO_US = 50_000,
  parameter int unsigned RATE_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [RATE_W-1:0] rate_khz_i,
  input  logic              cal_done_i,
  input  logic              dll_rdy_i,
  output logic              pdb_o,
  output logic              dll_en_o,
  output logic [1:0]        fsel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              warn_o
);
  localparam int unsigned CPU     = CLK_HZ / 1_000_000;
  localparam int unsigned SET_CYC = SETTLE_US * CPU;
  localparam int unsigned CAL_CYC = CAL_TMO_US * CPU;
  localparam int unsigned DLL_CYC = DLL_TMO_US * CPU;
  localparam int unsigned MAX_A   = (SET_CYC > CAL_CYC) ? SET_CYC : CAL_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > DLL_CYC) ? MAX_A : DLL_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DOWN, S_SETTLE, S_CAL, S_DLLEN, S_LOCK} st_t;

  st_t               st;
  logic              on_q;
  logic [RATE_W-1:0] rate_q;
  logic [CW-1:0]     cnt;
  logic [31:0]       r_now, r_held;

  assign r_now  = 32'(rate_khz_i);
  assign r_held = 32'(rate_q);
  assign busy_o = (st != S_IDLE);

  function automatic logic [1:0] band_of(logic [31:0] r);
    if (r == 32'd0)           return 2'd0;
    else if (r < 32'd75000)   return 2'd1;
    else if (r < 32'd125000)  return 2'd2;
    else if (r < 32'd175000)  return 2'd3;
    else                      return 2'd0;
  endfunction

  function automatic logic [31:0] ideal_of(logic [1:0] b);
    case (b)
      2'd1:    return 32'd50000;
      2'd2:    return 32'd100000;
      2'd3:    return 32'd150000;
      default: return 32'd200000;
    endcase
  endfunction

  function automatic logic warn_of(logic [31:0] r);
    logic [31:0] id, d;
    id = ideal_of(band_of(r));
    d  = (r > id) ? r - id : id - r;
    return (r > 32'd200000) || ((r > 32'd50000) && (d > 32'd15000));
  endfunction

  wire set_end = (cnt == CW'(SET_CYC - 1));
  wire cal_end = (cnt == CW'(CAL_CYC - 1));
  wire dll_end = (cnt == CW'(DLL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; on_q <= 1'b0; rate_q <= '0; cnt <= '0;
      pdb_o <= 1'b0; dll_en_o <= 1'b0; fsel_o <= 2'd0;
      done_o <= 1'b0; err_o <= 1'b0; warn_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: if (start_i || stop_i) begin
          st       <= S_DOWN;
          on_q     <= start_i;
          pdb_o    <= 1'b0;
          dll_en_o <= 1'b0;
          if (start_i) begin
            rate_q <= rate_khz_i;
            warn_o <= warn_of(r_now);
          end else begin
            warn_o <= 1'b0;
          end
        end
        S_DOWN: begin
          cnt <= '0;
          if (on_q) st <= S_SETTLE;
          else begin st <= S_IDLE; done_o <= 1'b1; end
        end
        S_SETTLE: begin
          if (set_end) begin
            pdb_o <= 1'b1; st <= S_CAL; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CAL: begin
          if (cal_done_i) begin
            fsel_o <= band_of(r_held); st <= S_DLLEN;
          end else if (cal_end) begin
            err_o <= 1'b1; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_DLLEN: begin
          dll_en_o <= 1'b1;
          cnt      <= '0;
          if (rate_q == '0) begin done_o <= 1'b1; st <= S_IDLE; end
          else st <= S_LOCK;
        end
        S_LOCK: begin
          if (dll_rdy_i) begin
            done_o <= 1'b1; st <= S_IDLE;
          end else if (dll_end) begin
            err_o <= 1'b1; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_down_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DOWN) |-> (!pdb_o && !dll_en_o));
  p_pdb_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdb_o) |-> $past(st == S_SETTLE));
  p_cal_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !dll_en_o) |-> ($past(!cal_done_i) && pdb_o));
  p_fsel_before_dll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> (pdb_o && $stable(fsel_o)));
  p_lock_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && dll_en_o) |-> $past(!dll_rdy_i));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/test_phy_pwr_seq.sv
module test_phy_pwr_seq;
  localparam int CLK_HZ = 4_000_000;
  localparam int MHZ    = CLK_HZ / 1_000_000;
  localparam int SET_N  = 3 * MHZ;
  localparam int CAL_N  = 50 * MHZ;
  localparam int DLL_N  = 100 * MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, cal_done_i = 1'b0, dll_rdy_i = 1'b0;
  logic [19:0] rate_khz_i = '0;
  logic pdb_o, dll_en_o, busy_o, done_o, err_o, warn_o;
  logic [1:0] fsel_o;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(3), .CAL_TMO_US(50),
                .DLL_TMO_US(100), .RATE_W(20)) i_phy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rate_khz_i(rate_khz_i), .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
    .pdb_o(pdb_o), .dll_en_o(dll_en_o), .fsel_o(fsel_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .warn_o(warn_o));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Reference model: phase 0 idle, 1 power-down step, 2 settle, 3 calibration poll,
  // 4 DLL enable, 5 lock poll.
  int ph = 0, el = 0, m_rate = 0;
  bit m_on = 0;
  int e_pdb = 0, e_en = 0, e_fsel = 0, e_done = 0, e_err = 0, e_warn = 0;

  function automatic int band(int r);
    if (r == 0) return 0;
    if (r < 75000) return 1;
    if (r < 125000) return 2;
    if (r < 175000) return 3;
    return 0;
  endfunction

  function automatic int warnf(int r);
    int ideal, d;
    int ideals[4] = '{200000, 50000, 100000, 150000};
    ideal = ideals[band(r)];
    d = (r > ideal) ? r - ideal : ideal - r;
    return ((r > 200000) || (r > 50000 && d > 15000)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; el = 0; e_pdb = 0; e_en = 0; e_fsel = 0; e_done = 0; e_err = 0; e_warn = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (ph == 0) begin
        if (start_i || stop_i) begin
          m_on = start_i; ph = 1; e_pdb = 0; e_en = 0;
          if (start_i) begin m_rate = int'(rate_khz_i); e_warn = warnf(m_rate); end
          else e_warn = 0;
        end
      end else if (ph == 1) begin
        if (m_on) begin ph = 2; el = 0; end
        else begin ph = 0; e_done = 1; end
      end else if (ph == 2) begin
        el++;
        if (el == SET_N) begin e_pdb = 1; ph = 3; el = 0; end
      end else if (ph == 3) begin
        if (cal_done_i) begin e_fsel = band(m_rate); ph = 4; end
        else begin el++; if (el == CAL_N) begin e_err = 1; ph = 0; end end
      end else if (ph == 4) begin
        e_en = 1; el = 0;
        if (m_rate == 0) begin e_done = 1; ph = 0; end else ph = 5;
      end else begin
        if (dll_rdy_i) begin e_done = 1; ph = 0; end
        else begin el++; if (el == DLL_N) begin e_err = 1; ph = 0; end end
      end
    end
  end

  task automatic chk(string nm, string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", rq, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("pdb_o",    "R3",  int'(pdb_o),    e_pdb);
    chk("dll_en_o", "R5",  int'(dll_en_o), e_en);
    chk("fsel_o",   "R8",  int'(fsel_o),   e_fsel);
    chk("warn_o",   "R9",  int'(warn_o),   e_warn);
    chk("busy_o",   "R10", int'(busy_o),   (ph != 0) ? 1 : 0);
    chk("done_o",   "R11", int'(done_o),   e_done);
    chk("err_o",    "R4",  int'(err_o),    e_err);
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // cal_at/dll_at: cycle after acceptance at which the status goes high (-1 never).
  // poke_at: cycle at which start and stop are both pulsed mid-sequence (R10).
  task automatic seq(input bit st, input int rate, input int cal_at, input int dll_at,
                     input int poke_at);
    @(negedge clk);
    start_i = st; stop_i = !st; rate_khz_i = 20'(rate);
    for (int k = 1; k < 5000; k++) begin
      @(negedge clk);
      start_i = (k == poke_at); stop_i = (k == poke_at);
      cal_done_i = (cal_at >= 0 && k >= cal_at);
      dll_rdy_i  = (dll_at >= 0 && k >= dll_at);
      if (!busy_o && k > 1) break;
    end
    start_i = 0; stop_i = 0; cal_done_i = 0; dll_rdy_i = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("pdb_o reset", "R1", int'(pdb_o), 0);
    chk("busy_o reset", "R1", int'(busy_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    seq(0, 0, -1, -1, -1);          // R2 stop from idle
    seq(1, 0, 20, -1, -1);          // R6 rate zero
    seq(1, 100000, 5, 30, 8);       // R7 lock, R10 requests ignored
    seq(1, 70000, 2, 10, -1);       // R9 warn low band
    seq(1, 30000, 2, 10, -1);       // R8 band 1 below 50 MHz
    seq(1, 250000, 2, 10, -1);      // R9 above 200 MHz
    seq(1, 140000, 2, 10, -1);      // R8 band 3
    seq(1, 174999, 2, 10, -1);      // R9 band 3 far
    seq(1, 175000, 2, 10, -1);      // R8 edge to code 0
    seq(1, 125000, 2, 10, -1);      // R8 edge to code 3
    seq(1, 74999, 2, 10, -1);       // R8 edge of code 1
    seq(1, 90000, -1, -1, -1);      // R4 calibration timeout
    seq(1, 50000, 3, -1, 50);       // R7 lock timeout
    seq(0, 0, -1, -1, -1);          // R2 stop after enabled
    @(negedge clk);
    start_i = 1; stop_i = 1; rate_khz_i = 20'd100000;   // R10 start wins
    @(negedge clk);
    start_i = 0; stop_i = 0;
    repeat (SET_N + 4) @(negedge clk);
    cal_done_i = 1; dll_rdy_i = 1;
    repeat (6) @(negedge clk);
    cal_done_i = 0; dll_rdy_i = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule